// File: doc/BRIEF.md
# Clocked controller for an asynchronous byte-wide non-volatile RAM

This block sits between a synchronous host and an asynchronous, byte-wide non-volatile RAM. The RAM is controlled by three active-low strobes: chip select, write strobe and output enable. The host sends one request at a time over a valid/ready handshake. The request carries a direction bit, an address and, for a write, a data byte. The controller turns each request into one bus cycle and signals completion with a one-cycle `done` pulse. For a read, the captured byte is presented on `rd_data` with that pulse.

Every analogue timing limit is a nanosecond parameter. Each one is converted to a whole number of clock cycles, rounded up, with a minimum of one. Writes are always ended by the write strobe, and output enable stays inactive for the whole write. After reset, and again after the supply-loss flag clears, the controller waits out a startup window before it will touch the bus. The same happens if the flag drops during a cycle.

Top module: `nvram_bus_ctrl`

## Requirements
- R1: While reset is asserted, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_drive` is 0, and `req_ready` and `done` are 0.
- R2: `req_ready` first rises ceil(T_STARTUP_NS/CLK_PERIOD_NS) clock edges after reset is released. No strobe goes low before then.
- R3: While `supply_lost` is 1, `req_ready` is 0. From the next edge on, all three strobes are 1 and the data driver is off, and any cycle in progress is dropped without `done`. After the flag clears, the full startup window of R2 runs again before `req_ready` returns.
- R4: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 exactly when no cycle is in progress and the startup window has ended.
- R5: A read holds `mem_ce_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for N_RD cycles, where N_RD = ceil(max(address access, output-enable access)/period). The byte is captured on the edge that releases the strobes. `done` follows N_RD + N_TURN edges after acceptance, where N_TURN = ceil(T_TURN_NS/period).
- R6: A write first spends one cycle with only `mem_ce_n` low. `mem_we_n` is then 0 for N_WP cycles, where N_WP is the largest of ceil(T_WP), ceil(T_DS) and ceil(T_AW)−1. `mem_we_n` and `mem_ce_n` rise on the same edge, and `mem_oe_n` is 1 throughout. `done` follows 1 + N_WP + N_REC edges after acceptance.
- R7: `mem_dq_drive` is 1 only from the edge where `mem_we_n` falls to one edge after it rises. It is never 1 while `mem_oe_n` is 0, nor within the turnaround time after a read's strobes rise.
- R8: `mem_addr` changes only when a request is accepted, and never while `mem_we_n` is 0. Successive address changes and successive falls of `mem_ce_n` are at least T_CYCLE_NS apart. A change after a write comes at least T_WR_NS after `mem_we_n` rises.
- R9: N_REC is the larger of ceil(T_WR_NS/period) and ceil(T_CYCLE_NS/period) − 1 − N_WP. This stretches the write recovery until the whole write meets the cycle time.
- R10: A read returns the byte most recently written to that address by an earlier request. This holds for any mix of addresses, including 0 and the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_lost | input | 1 | Supply-loss flag; forces the bus idle and restarts the startup window |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Byte captured by the last read |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | RAM address bus |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | DATA_W | Data toward the RAM |
| mem_dq_drive | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | DATA_W | Data from the RAM |

## Verification
The controller is tried with several request patterns:
- Writes to a spread of addresses followed by reads of all of them. This tells stored data apart from stale or undriven data.
- Alternating writes and immediate reads of the same address. These stress the turnaround and recovery gaps between opposite cycles.
- Back-to-back requests of the same kind. These separate cycle-time violations from correct spacing.
- A supply loss raised in the middle of a read, with a request already waiting when the flag clears. This shows the startup lockout is restarted and is not merely a delay on the first request.

The bench's bus model holds read data undefined until every access time has passed, so a capture made too early shows up as a wrong byte.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ACC,
    S_RD_TURN,
    S_WR_SETUP,
    S_WR_PULSE,
    S_WR_RECOV
  } nvc_state_e;

  // Whole cycles covering a nanosecond minimum, never fewer than one.
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvc_startup_gate.sv
module nvc_startup_gate #(
  parameter int N_START = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic open
);
  localparam int SW = $clog2(N_START + 1);

  logic [SW-1:0] cnt;

  assign open = (cnt == SW'(N_START));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (hold)     cnt <= '0;
    else if (!open)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nvc_phase_timer.sv
module nvc_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (!expired) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/nvram_bus_ctrl.sv
module nvram_bus_ctrl
  import nvc_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_CYCLE_NS    = 35,
  parameter int T_ACCESS_NS   = 35,
  parameter int T_OE_ACC_NS   = 15,
  parameter int T_WP_NS       = 15,
  parameter int T_DS_NS       = 10,
  parameter int T_AW_NS       = 18,
  parameter int T_WR_NS       = 12,
  parameter int T_TURN_NS     = 15,
  parameter int T_STARTUP_NS  = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_lost,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_drive,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int P       = CLK_PERIOD_NS;
  localparam int N_RD    = max2(ns_to_cyc(T_ACCESS_NS, P), ns_to_cyc(T_OE_ACC_NS, P));
  localparam int N_TURN  = ns_to_cyc(T_TURN_NS, P);
  localparam int N_WP    = max2(max2(ns_to_cyc(T_WP_NS, P), ns_to_cyc(T_DS_NS, P)),
                                max2(ns_to_cyc(T_AW_NS, P) - 1, 1));
  localparam int N_REC   = max2(ns_to_cyc(T_WR_NS, P), ns_to_cyc(T_CYCLE_NS, P) - 1 - N_WP);
  localparam int N_START = ns_to_cyc(T_STARTUP_NS, P);
  localparam int N_MAX   = max2(max2(N_RD, N_TURN), max2(N_WP, N_REC));
  localparam int CW      = $clog2(N_MAX + 1);

  nvc_state_e        state;
  logic              ce_q, we_q, oe_q, drv_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, rd_q;

  // Named internal events
  logic          start_done;
  logic          phase_done;
  logic          accept;
  logic          rd_capture;
  logic          wr_end;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;

  nvc_startup_gate #(.N_START(N_START)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (supply_lost),
    .open  (start_done)
  );

  nvc_phase_timer #(.W(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (phase_done)
  );

  assign req_ready  = (state == S_IDLE) && start_done && !supply_lost;
  assign accept     = req_valid && req_ready;
  assign rd_capture = (state == S_RD_ACC) && phase_done;
  assign wr_end     = (state == S_WR_PULSE) && phase_done;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (supply_lost) begin
      tmr_load = 1'b1;
    end else begin
      unique case (state)
        S_IDLE:     if (accept && !req_we) begin tmr_load = 1'b1; tmr_val = CW'(N_RD - 1); end
        S_WR_SETUP: begin tmr_load = 1'b1; tmr_val = CW'(N_WP - 1); end
        S_WR_PULSE: if (wr_end) begin tmr_load = 1'b1; tmr_val = CW'(N_REC - 1); end
        S_RD_ACC:   if (rd_capture) begin tmr_load = 1'b1; tmr_val = CW'(N_TURN - 1); end
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ce_q   <= 1'b1;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else if (supply_lost) begin
      state  <= S_IDLE;
      ce_q   <= 1'b1;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          addr_q <= req_addr;
          ce_q   <= 1'b0;
          if (req_we) begin
            wd_q  <= req_wdata;
            state <= S_WR_SETUP;
          end else begin
            oe_q  <= 1'b0;
            state <= S_RD_ACC;
          end
        end
        S_WR_SETUP: begin
          we_q  <= 1'b0;
          drv_q <= 1'b1;
          state <= S_WR_PULSE;
        end
        S_WR_PULSE: if (wr_end) begin
          we_q  <= 1'b1;
          ce_q  <= 1'b1;
          state <= S_WR_RECOV;
        end
        S_WR_RECOV: begin
          drv_q <= 1'b0;
          if (phase_done) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        S_RD_ACC: if (rd_capture) begin
          rd_q  <= mem_dq_in;
          ce_q  <= 1'b1;
          oe_q  <= 1'b1;
          state <= S_RD_TURN;
        end
        S_RD_TURN: if (phase_done) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_addr     = addr_q;
  assign mem_ce_n     = ce_q;
  assign mem_we_n     = we_q;
  assign mem_oe_n     = oe_q;
  assign mem_dq_out   = wd_q;
  assign mem_dq_drive = drv_q;
  assign rd_data      = rd_q;
  assign done         = done_q;

  // Length of the current write-strobe low phase, for the width check
  logic [CW:0] we_low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 we_low_len <= '0;
    else if (mem_we_n)          we_low_len <= '0;
    else if (we_low_len != '1)  we_low_len <= we_low_len + 1'b1;
  end

  a_r2_locked_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !start_done |-> (mem_ce_n && mem_we_n && mem_oe_n));

  a_r2_select_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $past(start_done));

  a_r3_loss_quiets_bus: assert property (@(posedge clk) disable iff (!rst_n)
    supply_lost |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_drive && !done));

  a_r5_capture_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!mem_ce_n && !mem_oe_n && mem_we_n));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_len >= (CW+1)'(N_WP)));

  a_r7_drive_safe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_drive |-> mem_oe_n);

  a_r8_addr_held_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> $stable(mem_addr));

endmodule

// File: tb/nvram_bus_ctrl_bench.sv
`timescale 1ns/1ps
module nvram_bus_ctrl_bench;
  localparam int CLK_NS     = 10;
  localparam int STARTUP_NS = 1000;
  localparam int AW = 19;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_lost = 1'b0;
  logic req_valid = 1'b0;
  logic req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive;
  logic [DW-1:0] rd_data, mem_dq_out, mdq;
  logic [AW-1:0] mem_addr;

  always #(CLK_NS/2) clk = ~clk;

  nvram_bus_ctrl #(.CLK_PERIOD_NS(CLK_NS), .T_STARTUP_NS(STARTUP_NS)) u_nvram_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_lost(supply_lost),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive), .mem_dq_in(mdq));

  int checks = 0;
  int failures = 0;

  // Cycle counts restated from the requirements (loop form)
  function automatic int cyc(input int ns);
    int c = 0;
    while (c * CLK_NS < ns) c++;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  int E_RD, E_TURN, E_WP, E_REC, E_START, RD_LAT, WR_LAT;
  initial begin
    E_RD    = mx(cyc(35), cyc(15));
    E_TURN  = cyc(15);
    E_WP    = mx(mx(cyc(15), cyc(10)), mx(cyc(18) - 1, 1));
    E_REC   = mx(cyc(12), cyc(35) - 1 - E_WP);
    E_START = cyc(STARTUP_NS);
    RD_LAT  = E_RD + E_TURN;
    WR_LAT  = 1 + E_WP + E_REC;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tcheck(input bit ok, input string tag, input real act, input real lim);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0.2f expected>=%0.2f t=%0t", tag, act, lim, $time);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // ---------------- bus model with timing checks ----------------
  logic [7:0] marr [int];
  real t_addr = -1.0e6, t_ce_fall = -1.0e6, t_ce_rise = -1.0e6;
  real t_oe_fall = -1.0e6, t_oe_rise = -1.0e6, t_we_fall = -1.0e6, t_we_rise = -1.0e6;
  real t_data = -1.0e6, t_ok = 1.0e18;
  bit  we_with_ce = 0;

  always @(posedge rst_n) t_ok = $realtime + STARTUP_NS;
  always @(posedge supply_lost) t_ok = 1.0e18;
  always @(negedge supply_lost) t_ok = $realtime + STARTUP_NS;

  always @(negedge mem_ce_n) if (rst_n) begin
    tcheck($realtime >= t_ok, "R2/R3 select inside startup window", $realtime, t_ok);
    tcheck($realtime - t_ce_fall >= 35.0, "R8 select-to-select spacing", $realtime - t_ce_fall, 35.0);
    tcheck($realtime - t_ce_rise >= 2.0, "R8 select high time", $realtime - t_ce_rise, 2.0);
    t_ce_fall = $realtime;
  end
  always @(posedge mem_ce_n) t_ce_rise = $realtime;
  always @(negedge mem_oe_n) if (rst_n) begin
    check(mem_we_n == 1'b1, "R6 output enable during write", mem_we_n, 1);
    t_oe_fall = $realtime;
  end
  always @(posedge mem_oe_n) t_oe_rise = $realtime;
  always @(negedge mem_we_n) if (rst_n) begin
    check(mem_oe_n == 1'b1, "R6 output enable high at write start", mem_oe_n, 1);
    tcheck($realtime - t_we_rise >= 2.0, "R6 write strobe high time", $realtime - t_we_rise, 2.0);
    we_with_ce = !mem_ce_n;
    t_we_fall = $realtime;
  end
  always @(posedge mem_we_n) if (rst_n) begin
    tcheck($realtime - t_we_fall >= 15.0, "R6 write pulse width", $realtime - t_we_fall, 15.0);
    tcheck($realtime - t_addr >= 18.0, "R8 address to end of write", $realtime - t_addr, 18.0);
    check(mem_dq_drive == 1'b1, "R7 data driven at end of write", mem_dq_drive, 1);
    tcheck($realtime - t_data >= 10.0, "R7 data setup to end of write", $realtime - t_data, 10.0);
    if (we_with_ce) marr[int'(mem_addr)] = mem_dq_out;
    t_we_rise = $realtime;
  end
  always @(mem_dq_out or mem_dq_drive) t_data = $realtime;
  always @(posedge mem_dq_drive) if (rst_n) begin
    check(mem_oe_n == 1'b1, "R7 drive while output enabled", mem_oe_n, 1);
    tcheck($realtime - t_oe_rise >= 10.0, "R7 turnaround after output enable", $realtime - t_oe_rise, 10.0);
    tcheck($realtime - t_ce_rise >= 15.0, "R7 turnaround after select", $realtime - t_ce_rise, 15.0);
  end
  always @(mem_addr) if (rst_n) begin
    check(mem_we_n == 1'b1, "R8 address moved during write", mem_we_n, 1);
    tcheck($realtime - t_we_rise >= 12.0, "R8 write recovery", $realtime - t_we_rise, 12.0);
    tcheck($realtime - t_addr >= 35.0, "R8 address cycle time", $realtime - t_addr, 35.0);
    t_addr = $realtime;
  end

  // Read data is undefined until every access time has passed
  initial begin
    mdq = 'x;
    forever begin
      #1;
      if (!mem_ce_n && !mem_oe_n && mem_we_n &&
          $realtime - t_addr >= 35.0 && $realtime - t_ce_fall >= 35.0 &&
          $realtime - t_oe_fall >= 15.0)
        mdq = marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : 8'h00;
      else
        mdq = 'x;
    end
  end

  // ---------------- cycle-by-cycle reference ----------------
  logic [7:0] shadow [int];
  int  st_cnt = 0, busy = 0;
  bit  exp_ready_q = 0, exp_done = 0, pend_rd = 0, done_rd = 0;
  logic [7:0] pend_val = 0, done_val = 0;

  always @(posedge clk) begin
    if (!rst_n || supply_lost) begin
      st_cnt = 0; busy = 0; exp_done = 0; pend_rd = 0;
    end else begin
      bit rdy;
      rdy = (st_cnt == E_START) && (busy == 0);
      exp_done = 0;
      if (busy > 0) begin
        busy--;
        if (busy == 0) begin exp_done = 1; done_rd = pend_rd; done_val = pend_val; end
      end else if (rdy && req_valid) begin
        if (req_we) begin
          shadow[int'(req_addr)] = req_wdata;
          busy = WR_LAT; pend_rd = 0;
        end else begin
          pend_val = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 8'h00;
          busy = RD_LAT; pend_rd = 1;
        end
      end
      if (st_cnt < E_START) st_cnt++;
    end
    exp_ready_q = rst_n && (st_cnt == E_START) && (busy == 0);
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check(req_ready == (exp_ready_q && !supply_lost), "R4 ready per cycle", req_ready, exp_ready_q && !supply_lost);
      check(done == exp_done, "R5/R6 done timing", done, exp_done);
      if (exp_done && done_rd)
        check(rd_data === done_val, "R10 read data", rd_data, done_val);
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle;
    repeat (RD_LAT + WR_LAT + 4) @(negedge clk);
  endtask

  initial begin
    repeat (1000000 / CLK_NS) @(posedge clk);
    failures++;
    $display("FAIL watchdog R4 actual=hung expected=complete");
    finish_run();
  end

  logic [AW-1:0] alist [24];

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #2;
    check(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    check(!mem_dq_drive && !req_ready && !done, "R1 idle outputs in reset", {mem_dq_drive, req_ready, done}, 0);

    // R2 startup boundary
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < E_START - 1; i++) @(posedge clk);
    #1;
    check(req_ready == 1'b0, "R2 ready one edge early", req_ready, 0);
    @(posedge clk); #1;
    check(req_ready == 1'b1, "R2 ready at window end", req_ready, 1);

    for (int i = 0; i < 24; i++) alist[i] = AW'($urandom_range(0, (1 << AW) - 1));
    alist[0] = '0;
    alist[1] = '1;

    // Writes then reads over a spread of addresses (R6, R5, R10)
    for (int i = 0; i < 24; i++) issue(1'b1, alist[i], 8'($urandom));
    for (int i = 0; i < 24; i++) issue(1'b0, alist[i], 8'h00);

    // Alternating write and immediate read (R7 turnaround, R9 recovery)
    for (int i = 0; i < 16; i++) begin
      int k = $urandom_range(0, 23);
      issue(1'b1, alist[k], 8'($urandom));
      issue(1'b0, alist[k], 8'h00);
      issue(1'b0, alist[(k + 1) % 24], 8'h00);
    end
    wait_idle();

    // R3 supply loss in the middle of a read
    issue(1'b0, alist[3], 8'h00);
    supply_lost = 1'b1;
    @(posedge clk); #1;
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_drive, "R3 strobes released on loss",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_drive}, 4'b1110);
    check(req_ready == 1'b0, "R3 ready low during loss", req_ready, 0);
    repeat (5) @(negedge clk);
    supply_lost = 1'b0;
    begin
      int n = 0;
      @(posedge clk); #1;
      n = 1;
      while (!req_ready && n < 4 * E_START) begin @(posedge clk); #1; n++; end
      check(n == E_START, "R3 startup window rerun", n, E_START);
    end

    // Request waiting across the lockout, then read-back (R3, R10)
    @(negedge clk) supply_lost = 1'b1;
    @(negedge clk) supply_lost = 1'b0;
    issue(1'b0, alist[5], 8'h00);
    for (int i = 0; i < 8; i++) issue(1'b0, alist[i], 8'h00);
    wait_idle();
    finish_run();
  end
endmodule